// File: doc/BRIEF.md
# Oversampled Serial Receiver with Frame Filtering

This block is the receive front end of an asynchronous serial port. It picks its input from either the RX pin or the local transmit line (loopback), can invert it, and synchronizes it into the clock domain. It samples the line once per oversample tick and finds the falling edge of a start bit. The start bit is then checked again at mid-bit. Data, optional parity and the first stop bit are each read at the middle of their bit period. By default each read is a majority vote over three consecutive samples.

Each completed frame produces a single write on the queue write port. The write carries the 9-bit data word, zero-extended, plus separate parity-error and framing-error flags. A receive-blocking state decides whether a frame is written at all. Frames that match a programmed start value or signal value, and address frames in multi-processor mode, raise single-cycle event pulses. A start-value match can optionally release the blocking. The queue storage, bus registers and baud-rate generator are outside this block. The oversample tick comes from outside.

Top module: `rx_frame_filter`

## Requirements
- R1: `cfg_ovs_i` sets the ticks per bit: 0 gives 16, 1 gives 8, 2 gives 6, 3 gives 4. Code 4 and above give one tick per bit. In that case every bit is read on its single tick and no vote is taken.
- R2: With oversampling on, a bit is read at tick index N/2 of its period (index 0 is the first tick of the bit). With `cfg_vote_off_i`=0 the value is the majority of the ticks at indices N/2-2, N/2-1 and N/2. With `cfg_vote_off_i`=1 only the sample at index N/2 is used.
- R3: A low level seen while idle starts a frame. If the start bit reads high at its mid-bit point, the receiver goes back to idle and no write happens.
- R4: `cfg_dbits_i` gives 7 (1), 8 (2) or 9 (3) data bits. Bits arrive LSB first, or MSB first when `cfg_msb_first_i`=1. The word is zero-extended to 9 bits.
- R5: `cfg_parity_i` selects parity: 0 none, 2 even, 3 odd. A parity bit that does not match the data sets `q_perr_o`. With parity off, `q_perr_o` stays 0.
- R6: `cfg_stop_i`=0 (half stop) skips the stop-bit check. Codes 1 to 3 check only the first stop bit, and a low value there sets `q_ferr_o`.
- R7: Each frame that is accepted gives exactly one single-cycle `q_wr_o` pulse. The pulse carries the data and both error flags. Frames with errors are still written.
- R8: `cfg_rx_inv_i`=1 inverts the selected line before sampling. `cfg_loopback_i`=1 takes the line from `tx_loop_i` and ignores `rx_pin_i`. With 0, `tx_loop_i` is ignored.
- R9: `block_set_i` sets blocking and `block_clr_i` clears it; clear wins. While blocking is on, frames that match no exception are dropped and not written.
- R10: With `cfg_mp_en_i`=1 and 9 data bits, a frame whose bit 8 equals `cfg_mp_addr_i` is written even while blocked and pulses `ev_addr_o`.
- R11: A frame equal to `cfg_start_val_i` pulses `ev_start_o`. With `cfg_start_unblock_i`=1 it also clears blocking, and that frame is written.
- R12: A frame equal to `cfg_sig_val_i` pulses `ev_sig_o`. This does not change blocking or whether the frame is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_pin_i | input | 1 | Serial input pin |
| tx_loop_i | input | 1 | Local transmit line, used in loopback |
| os_tick_i | input | 1 | Oversample tick, one cycle wide |
| cfg_ovs_i | input | 3 | Oversampling code |
| cfg_vote_off_i | input | 1 | Turn off the three-sample majority vote |
| cfg_dbits_i | input | 2 | Data-bit count code |
| cfg_parity_i | input | 2 | Parity mode code |
| cfg_stop_i | input | 2 | Stop-bit mode code |
| cfg_msb_first_i | input | 1 | MSB-first bit order |
| cfg_rx_inv_i | input | 1 | Invert the input line |
| cfg_loopback_i | input | 1 | Take the input from tx_loop_i |
| cfg_mp_en_i | input | 1 | Multi-processor address mode |
| cfg_mp_addr_i | input | 1 | Bit-8 value that marks an address frame |
| cfg_start_val_i | input | 9 | Start-frame match value |
| cfg_sig_val_i | input | 9 | Signal-frame match value |
| cfg_start_unblock_i | input | 1 | A start-frame match clears blocking |
| block_set_i | input | 1 | Set receive blocking |
| block_clr_i | input | 1 | Clear receive blocking |
| q_wr_o | output | 1 | Queue write strobe |
| q_data_o | output | 9 | Received data word |
| q_perr_o | output | 1 | Parity error flag of the word |
| q_ferr_o | output | 1 | Framing error flag of the word |
| blocked_o | output | 1 | Receive blocking state |
| ev_addr_o | output | 1 | Address-frame event pulse |
| ev_start_o | output | 1 | Start-frame match event pulse |
| ev_sig_o | output | 1 | Signal-frame match event pulse |

## Verification
The bench uses the default 9-bit word width and a two-stage synchronizer. It drives one oversample tick every four clocks and changes the line right after a tick. Because of this, the first tick that sees a new level is always index 0 of the bit. A one-tick glitch can therefore be placed exactly on the mid-bit sample, and it must be voted away with the vote on and must show up with the vote off. The same tick pacing reaches every ratio from 16 down to one tick per bit. It also lets a framing error on the stop bit run into a false start that the receiver must reject.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned MAX_DW = 9;
  localparam int unsigned TCNT_W = 5;
  localparam int unsigned IDX_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [MAX_DW-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_word_t;

  function automatic logic [TCNT_W-1:0] ovs_ticks(input logic [2:0] code);
    case (code)
      3'd0:    return TCNT_W'(16);
      3'd1:    return TCNT_W'(8);
      3'd2:    return TCNT_W'(6);
      3'd3:    return TCNT_W'(4);
      default: return TCNT_W'(1);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] data_len(input logic [1:0] code);
    case (code)
      2'd1:    return IDX_W'(7);
      2'd3:    return IDX_W'(9);
      default: return IDX_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/rxf_line_cond.sv
module rxf_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic loop_i,
  input  logic loopback_i,
  input  logic invert_i,
  input  logic tick_i,
  input  logic vote_off_i,
  input  logic os_off_i,
  output logic line_o,
  output logic bit_o
);
  logic raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0] hist_q;
  logic vote;

  assign raw = (loopback_i ? loop_i : pin_i) ^ invert_i;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= raw;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      end
    end
  endgenerate

  assign line_o = sync_q[SYNC_STAGES-1];

  // two previous tick samples, oldest in bit 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= 2'b11;
    else if (tick_i) hist_q <= {hist_q[0], line_o};
  end

  assign vote  = (line_o & hist_q[0]) | (line_o & hist_q[1]) | (hist_q[0] & hist_q[1]);
  assign bit_o = (vote_off_i || os_off_i) ? line_o : vote;
endmodule

// File: rtl/rxf_bit_engine.sv
module rxf_bit_engine
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       bit_i,
  input  logic [2:0] ovs_i,
  input  logic [1:0] dbits_i,
  input  logic [1:0] parity_i,
  input  logic [1:0] stop_i,
  input  logic       msb_first_i,
  output logic       os_off_o,
  output logic       done_o,
  output rx_word_t   word_o
);
  localparam logic [IDX_W-1:0] DW_L = IDX_W'(MAX_DW);

  rx_state_e st_q, st_d;
  logic [TCNT_W-1:0] cnt_q, cnt_d, ratio, half, last;
  logic [IDX_W-1:0]  idx_q, idx_d, nd;
  logic [MAX_DW-1:0] sh_q, sh_d;
  logic par_q, par_d, pbit_q, pbit_d;
  logic done_q, done_d;
  rx_word_t word_q, word_d;
  logic sample, at_end, par_en, par_odd;

  assign ratio    = ovs_ticks(ovs_i);
  assign half     = ratio >> 1;
  assign last     = ratio - TCNT_W'(1);
  assign os_off_o = (ratio == TCNT_W'(1));
  assign nd       = data_len(dbits_i);
  assign par_en   = parity_i[1];
  assign par_odd  = (parity_i == 2'd3);
  assign sample   = (cnt_q == half);
  assign at_end   = (cnt_q == last);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    pbit_d = pbit_q;
    done_d = 1'b0;
    word_d = word_q;
    if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!line_i) begin
            idx_d = '0;
            sh_d  = '0;
            par_d = 1'b0;
            st_d  = os_off_o ? ST_DATA : ST_START;
            cnt_d = os_off_o ? '0 : TCNT_W'(1);
          end
        end
        ST_START: begin
          if (sample && bit_i) begin
            st_d  = ST_IDLE;   // false start
            cnt_d = '0;
          end else if (at_end) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + TCNT_W'(1);
          end
        end
        ST_DATA: begin
          if (sample) begin
            sh_d  = msb_first_i ? {sh_q[MAX_DW-2:0], bit_i} : {bit_i, sh_q[MAX_DW-1:1]};
            par_d = par_q ^ bit_i;
            idx_d = idx_q + IDX_W'(1);
          end
          if (at_end) begin
            cnt_d = '0;
            if (idx_d == nd) st_d = par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt_d = cnt_q + TCNT_W'(1);
          end
        end
        ST_PAR: begin
          if (sample) pbit_d = bit_i;
          if (at_end) begin
            cnt_d = '0;
            st_d  = ST_STOP;
          end else begin
            cnt_d = cnt_q + TCNT_W'(1);
          end
        end
        ST_STOP: begin
          if (sample) begin
            done_d      = 1'b1;
            word_d.data = msb_first_i ? sh_q : (sh_q >> (DW_L - nd));
            word_d.perr = par_en && ((par_q ^ pbit_q) != par_odd);
            word_d.ferr = (stop_i != 2'd0) && !bit_i;
            st_d        = ST_IDLE;
            cnt_d       = '0;
          end else begin
            cnt_d = cnt_q + TCNT_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      pbit_q <= pbit_d;
      done_q <= done_d;
      word_q <= word_d;
    end
  end

  assign done_o = done_q;
  assign word_o = word_q;
endmodule

// File: rtl/rxf_frame_filter.sv
module rxf_frame_filter
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_word_t          word_i,
  input  logic [1:0]        dbits_i,
  input  logic              mp_en_i,
  input  logic              mp_addr_i,
  input  logic [MAX_DW-1:0] start_val_i,
  input  logic [MAX_DW-1:0] sig_val_i,
  input  logic              start_unblock_i,
  input  logic              block_set_i,
  input  logic              block_clr_i,
  output logic              wr_o,
  output rx_word_t          word_o,
  output logic              blocked_o,
  output logic              ev_addr_o,
  output logic              ev_start_o,
  output logic              ev_sig_o
);
  logic addr_hit, start_hit, sig_hit, unblk, blk_q;
  logic wr_q, ev_addr_q, ev_start_q, ev_sig_q;
  rx_word_t word_q;

  assign addr_hit  = mp_en_i && (dbits_i == 2'd3) && (word_i.data[MAX_DW-1] == mp_addr_i);
  assign start_hit = (word_i.data == start_val_i);
  assign sig_hit   = (word_i.data == sig_val_i);
  assign unblk     = start_hit && start_unblock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            blk_q <= 1'b0;
    else if (block_clr_i || (done_i && unblk)) blk_q <= 1'b0;
    else if (block_set_i)                   blk_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= 1'b0;
      ev_addr_q  <= 1'b0;
      ev_start_q <= 1'b0;
      ev_sig_q   <= 1'b0;
      word_q     <= '0;
    end else begin
      wr_q       <= done_i && (!blk_q || addr_hit || unblk);
      ev_addr_q  <= done_i && addr_hit;
      ev_start_q <= done_i && start_hit;
      ev_sig_q   <= done_i && sig_hit;
      if (done_i) word_q <= word_i;
    end
  end

  assign wr_o       = wr_q;
  assign word_o     = word_q;
  assign blocked_o  = blk_q;
  assign ev_addr_o  = ev_addr_q;
  assign ev_start_o = ev_start_q;
  assign ev_sig_o   = ev_sig_q;
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_pin_i,
  input  logic              tx_loop_i,
  input  logic              os_tick_i,
  input  logic [2:0]        cfg_ovs_i,
  input  logic              cfg_vote_off_i,
  input  logic [1:0]        cfg_dbits_i,
  input  logic [1:0]        cfg_parity_i,
  input  logic [1:0]        cfg_stop_i,
  input  logic              cfg_msb_first_i,
  input  logic              cfg_rx_inv_i,
  input  logic              cfg_loopback_i,
  input  logic              cfg_mp_en_i,
  input  logic              cfg_mp_addr_i,
  input  logic [MAX_DW-1:0] cfg_start_val_i,
  input  logic [MAX_DW-1:0] cfg_sig_val_i,
  input  logic              cfg_start_unblock_i,
  input  logic              block_set_i,
  input  logic              block_clr_i,
  output logic              q_wr_o,
  output logic [MAX_DW-1:0] q_data_o,
  output logic              q_perr_o,
  output logic              q_ferr_o,
  output logic              blocked_o,
  output logic              ev_addr_o,
  output logic              ev_start_o,
  output logic              ev_sig_o
);
  logic line_s, bit_s, os_off, eng_done;
  rx_word_t eng_word, q_word;

  rxf_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (rx_pin_i),
    .loop_i     (tx_loop_i),
    .loopback_i (cfg_loopback_i),
    .invert_i   (cfg_rx_inv_i),
    .tick_i     (os_tick_i),
    .vote_off_i (cfg_vote_off_i),
    .os_off_i   (os_off),
    .line_o     (line_s),
    .bit_o      (bit_s)
  );

  rxf_bit_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (os_tick_i),
    .line_i      (line_s),
    .bit_i       (bit_s),
    .ovs_i       (cfg_ovs_i),
    .dbits_i     (cfg_dbits_i),
    .parity_i    (cfg_parity_i),
    .stop_i      (cfg_stop_i),
    .msb_first_i (cfg_msb_first_i),
    .os_off_o    (os_off),
    .done_o      (eng_done),
    .word_o      (eng_word)
  );

  rxf_frame_filter u_filt (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .done_i          (eng_done),
    .word_i          (eng_word),
    .dbits_i         (cfg_dbits_i),
    .mp_en_i         (cfg_mp_en_i),
    .mp_addr_i       (cfg_mp_addr_i),
    .start_val_i     (cfg_start_val_i),
    .sig_val_i       (cfg_sig_val_i),
    .start_unblock_i (cfg_start_unblock_i),
    .block_set_i     (block_set_i),
    .block_clr_i     (block_clr_i),
    .wr_o            (q_wr_o),
    .word_o          (q_word),
    .blocked_o       (blocked_o),
    .ev_addr_o       (ev_addr_o),
    .ev_start_o      (ev_start_o),
    .ev_sig_o        (ev_sig_o)
  );

  assign q_data_o = q_word.data;
  assign q_perr_o = q_word.perr;
  assign q_ferr_o = q_word.ferr;
endmodule

// File: rtl/rx_frame_filter_chk.sv
module rx_frame_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eng_done,
  input logic       q_wr_o,
  input logic       q_perr_o,
  input logic       q_ferr_o,
  input logic       blocked_o,
  input logic       ev_addr_o,
  input logic       ev_start_o,
  input logic       block_clr_i,
  input logic [1:0] cfg_stop_i,
  input logic [1:0] cfg_parity_i,
  input logic [1:0] cfg_dbits_i,
  input logic       cfg_mp_en_i,
  input logic       cfg_start_unblock_i
);
  p_wr_from_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_o |-> $past(eng_done));

  p_wr_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_o |=> !q_wr_o);

  p_drop_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_o |-> (!$past(blocked_o) || ev_addr_o || (ev_start_o && cfg_start_unblock_i)));

  p_ferr_checked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_wr_o && q_ferr_o) |-> (cfg_stop_i != 2'd0));

  p_perr_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_wr_o && q_perr_o) |-> cfg_parity_i[1]);

  p_addr_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_addr_o |-> (cfg_mp_en_i && (cfg_dbits_i == 2'd3)));

  p_unblock_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blocked_o) |-> ($past(block_clr_i) || (ev_start_o && cfg_start_unblock_i)));
endmodule

bind rx_frame_filter rx_frame_filter_chk u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .eng_done            (eng_done),
  .q_wr_o              (q_wr_o),
  .q_perr_o            (q_perr_o),
  .q_ferr_o            (q_ferr_o),
  .blocked_o           (blocked_o),
  .ev_addr_o           (ev_addr_o),
  .ev_start_o          (ev_start_o),
  .block_clr_i         (block_clr_i),
  .cfg_stop_i          (cfg_stop_i),
  .cfg_parity_i        (cfg_parity_i),
  .cfg_dbits_i         (cfg_dbits_i),
  .cfg_mp_en_i         (cfg_mp_en_i),
  .cfg_start_unblock_i (cfg_start_unblock_i)
);

// File: tb/rx_frame_filter_bench.sv
`timescale 1ns/1ps
module rx_frame_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic rx_pin = 1'b1, tx_loop = 1'b0;
  logic [1:0] tdiv;
  logic os_tick;
  logic [2:0] c_ovs = 3'd3;
  logic c_vote_off = 1'b0, c_msb = 1'b0, c_inv = 1'b0, c_lb = 1'b0;
  logic [1:0] c_db = 2'd2, c_par = 2'd0, c_stop = 2'd1;
  logic c_mp = 1'b0, c_ab = 1'b0, c_unblk = 1'b0;
  logic [8:0] c_sv = 9'h1FF, c_gv = 9'h1FE;
  logic blk_set = 1'b0, blk_clr = 1'b0;

  logic q_wr, q_perr, q_ferr, blocked, ev_addr, ev_start, ev_sig;
  logic [8:0] q_data;

  rx_frame_filter u_rx_frame_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_pin_i(rx_pin), .tx_loop_i(tx_loop), .os_tick_i(os_tick),
    .cfg_ovs_i(c_ovs), .cfg_vote_off_i(c_vote_off), .cfg_dbits_i(c_db), .cfg_parity_i(c_par),
    .cfg_stop_i(c_stop), .cfg_msb_first_i(c_msb), .cfg_rx_inv_i(c_inv), .cfg_loopback_i(c_lb),
    .cfg_mp_en_i(c_mp), .cfg_mp_addr_i(c_ab), .cfg_start_val_i(c_sv), .cfg_sig_val_i(c_gv),
    .cfg_start_unblock_i(c_unblk), .block_set_i(blk_set), .block_clr_i(blk_clr),
    .q_wr_o(q_wr), .q_data_o(q_data), .q_perr_o(q_perr), .q_ferr_o(q_ferr),
    .blocked_o(blocked), .ev_addr_o(ev_addr), .ev_start_o(ev_start), .ev_sig_o(ev_sig)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, addr_cnt = 0, start_cnt = 0, sig_cnt = 0;
  logic [8:0] last_data;
  logic last_perr, last_ferr;
  bit m_blk = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (q_wr) begin wr_cnt++; last_data = q_data; last_perr = q_perr; last_ferr = q_ferr; end
    if (ev_addr)  addr_cnt++;
    if (ev_start) start_cnt++;
    if (ev_sig)   sig_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] c);
    case (c) 3'd0: return 16; 3'd1: return 8; 3'd2: return 6; 3'd3: return 4; default: return 1; endcase
  endfunction

  function automatic int nd_of(input logic [1:0] c);
    return (c == 2'd1) ? 7 : (c == 2'd3) ? 9 : 8;
  endfunction

  task automatic drive(input bit v, input int n);
    if (c_lb) begin tx_loop = v ^ c_inv; rx_pin = c_inv; end
    else      begin rx_pin = v ^ c_inv; tx_loop = c_inv; end
    repeat (n) begin
      @(negedge clk);
      while (!os_tick) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulse(input bit set_not_clr);
    @(negedge clk);
    if (set_not_clr) blk_set = 1'b1; else blk_clr = 1'b1;
    @(negedge clk);
    blk_set = 1'b0; blk_clr = 1'b0;
    if (set_not_clr) m_blk = 1'b1; else m_blk = 1'b0;
    drive(1'b1, 2);
  endtask

  // gi: data-bit index (in send order) that gets a one-tick glitch on its sample point, -1 none
  task automatic run_frame(input int d, input int gi, input bit bad_par, input bit bad_stop, input string tag);
    int n, h, nd, mask, dd, rx, pos, w0, a0, s0, g0;
    bit flip, par_en, p, exp_addr, exp_start, exp_sig, exp_wr, exp_perr, exp_ferr;
    n = ratio_of(c_ovs); h = n / 2; nd = nd_of(c_db);
    mask = (1 << nd) - 1; dd = d & mask;
    par_en = c_par[1];
    flip = (gi >= 0) && c_vote_off;
    pos = (gi < 0) ? 0 : (c_msb ? nd - 1 - gi : gi);
    rx = flip ? (dd ^ (1 << pos)) : dd;
    w0 = wr_cnt; a0 = addr_cnt; s0 = start_cnt; g0 = sig_cnt;
    drive(1'b0, n);
    for (int i = 0; i < nd; i++) begin
      int bp;
      bit v;
      bp = c_msb ? nd - 1 - i : i;
      v = ((dd >> bp) & 1) != 0;
      if (i == gi) begin drive(v, h); drive(!v, 1); drive(v, n - h - 1); end
      else drive(v, n);
    end
    if (par_en) begin
      p = (^(dd[8:0])) ^ (c_par == 2'd3) ^ bad_par;
      drive(p, n);
    end
    drive(!bad_stop, n);
    drive(1'b1, 3 * n + 4);
    exp_addr  = c_mp && (nd == 9) && (((rx >> 8) & 1) == int'(c_ab));
    exp_start = (rx == int'(c_sv));
    exp_sig   = (rx == int'(c_gv));
    exp_wr    = !m_blk || exp_addr || (exp_start && c_unblk);
    if (exp_start && c_unblk) m_blk = 1'b0;
    exp_perr  = par_en && (bad_par ^ flip);
    exp_ferr  = (c_stop != 2'd0) && bad_stop;
    check(wr_cnt - w0 == (exp_wr ? 1 : 0), "R9 write count", wr_cnt - w0, exp_wr ? 1 : 0);
    if (exp_wr && wr_cnt - w0 == 1) begin
      check(int'(last_data) == rx, tag, last_data, rx);
      check(last_perr == exp_perr, "R5 parity flag", last_perr, exp_perr);
      check(last_ferr == exp_ferr, "R6 framing flag", last_ferr, exp_ferr);
    end
    check(addr_cnt - a0 == (exp_addr ? 1 : 0), "R10 addr event", addr_cnt - a0, exp_addr ? 1 : 0);
    check(start_cnt - s0 == (exp_start ? 1 : 0), "R11 start event", start_cnt - s0, exp_start ? 1 : 0);
    check(sig_cnt - g0 == (exp_sig ? 1 : 0), "R12 sig event", sig_cnt - g0, exp_sig ? 1 : 0);
    check(blocked == m_blk, "R11 blocked state", blocked, m_blk);
  endtask

  task automatic set_cfg(input int ovs, input int db, input int par, input int stp,
                         input bit msb, input bit voff, input bit inv, input bit lb);
    @(negedge clk);
    c_ovs = 3'(ovs); c_db = 2'(db); c_par = 2'(par); c_stop = 2'(stp);
    c_msb = msb; c_vote_off = voff; c_inv = inv; c_lb = lb;
    if (lb) begin tx_loop = ~inv; rx_pin = inv; end
    else    begin rx_pin = ~inv; tx_loop = inv; end
    drive(1'b1, 4);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(q_wr == 1'b0, "R7 reset write", q_wr, 0);
    check(blocked == 1'b0, "R9 reset blocked", blocked, 0);
    check({ev_addr, ev_start, ev_sig} == 3'b000, "R12 reset events", {ev_addr, ev_start, ev_sig}, 0);
    set_cfg(3, 2, 0, 1, 0, 0, 0, 0);

    // R3: false start of 3 ticks at 16x
    set_cfg(0, 2, 0, 1, 0, 0, 0, 0);
    begin
      int w0;
      w0 = wr_cnt;
      drive(1'b0, 3); drive(1'b1, 40);
      check(wr_cnt == w0, "R3 false start", wr_cnt - w0, 0);
    end
    run_frame(9'h0C3, -1, 0, 0, "R1 16x data");

    // R2: glitch on sample point, vote on then off
    set_cfg(1, 2, 2, 1, 0, 0, 0, 0);
    run_frame(9'h05A, 3, 0, 0, "R2 vote removes glitch");
    set_cfg(1, 2, 2, 1, 0, 1, 0, 0);
    run_frame(9'h05A, 3, 0, 0, "R2 vote off keeps glitch");

    // R1: one tick per bit
    set_cfg(4, 3, 3, 2, 1, 0, 0, 0);
    run_frame(9'h1A7, -1, 0, 0, "R1 no oversampling");
    set_cfg(2, 1, 0, 1, 0, 0, 0, 0);
    run_frame(9'h07F, -1, 0, 0, "R1 6x seven bits");

    // R5/R6/R7: errored frames still written, half stop not checked
    set_cfg(3, 2, 3, 1, 0, 0, 0, 0);
    run_frame(9'h0E1, -1, 1, 0, "R7 odd parity error written");
    set_cfg(3, 2, 2, 3, 0, 0, 0, 0);
    run_frame(9'h0E1, -1, 0, 1, "R7 framing error written");
    set_cfg(3, 2, 0, 0, 0, 0, 0, 0);
    run_frame(9'h012, -1, 0, 1, "R6 half stop unchecked");

    // R8: invert and loopback
    set_cfg(3, 2, 0, 1, 0, 0, 1, 0);
    run_frame(9'h0B4, -1, 0, 0, "R8 inverted line");
    set_cfg(3, 2, 0, 1, 0, 0, 1, 1);
    run_frame(9'h04B, -1, 0, 0, "R8 loopback pin ignored");

    // R9..R12: blocking and matching
    set_cfg(3, 3, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    c_mp = 1'b1; c_ab = 1'b1; c_sv = 9'h055; c_gv = 9'h0AA; c_unblk = 1'b0;
    pulse(1'b1);
    check(blocked == 1'b1, "R9 block set", blocked, 1);
    run_frame(9'h033, -1, 0, 0, "R9 dropped");
    run_frame(9'h1C4, -1, 0, 0, "R10 address frame passes");
    run_frame(9'h055, -1, 0, 0, "R11 start no unblock");
    run_frame(9'h0AA, -1, 0, 0, "R12 signal frame");
    @(negedge clk); c_unblk = 1'b1;
    run_frame(9'h055, -1, 0, 0, "R11 start unblocks");
    run_frame(9'h033, -1, 0, 0, "R9 open again");
    pulse(1'b1);
    pulse(1'b0);
    check(blocked == 1'b0, "R9 block cleared", blocked, 0);
    run_frame(9'h0AA, -1, 0, 0, "R12 signal while open");
    @(negedge clk);
    c_mp = 1'b0; c_unblk = 1'b0; c_sv = 9'h1FF; c_gv = 9'h1FE;

    // random configurations
    for (int k = 0; k < 60; k++) begin
      int ovs, db, par, stp, gi, d;
      bit msb, voff, inv, lb, bp, bs;
      string tg;
      ovs = $urandom % 5; db = 1 + ($urandom % 3);
      par = $urandom % 3; if (par != 0) par = par + 1;
      stp = $urandom % 4;
      msb = $urandom % 2; voff = $urandom % 2; inv = $urandom % 2; lb = $urandom % 2;
      gi = (ovs < 4 && ($urandom % 2 == 1)) ? int'($urandom % 7) : -1;
      bp = (par != 0) && ($urandom % 8 == 0);
      bs = ($urandom % 8 == 0);
      d = $urandom % 512;
      tg = (inv || lb) ? "R8 random data" : "R4 random data";
      set_cfg(ovs, db, par, stp, msb, voff, inv, lb);
      run_frame(d, gi, bp, bs, tg);
    end

    finished = 1'b1;
    report();
  end
endmodule